// File: doc/BRIEF.md
# Serial Codec Register Access Port

This block sits between a processor's register bus and an external codec reached over a serial frame link. Software writes one command word that holds a 4-bit codec register address, a write flag and 16 data bits. The port then sends a 32-bit request frame and collects a 16-bit reply. When the transaction ends, the port sets a sticky completion flag. After a read, the low half of the same command register holds the value the codec returned.

A control register holds the port enable and a 7-bit telecom sample-rate divisor. The port uses the divisor to emit a one-cycle rate strobe every 32 × divisor clocks. The serial side has four wires: a bit clock, a frame sync, serial data out and serial data in. Only one codec transaction can be in flight at a time.

Top module: `scrp_port`

## Requirements
- R1: A command word carries the codec register address in bits 20:17, the write flag in bit 16 and data in bits 15:0. The outbound frame is 32 bits, sent MSB first, with bits 31:21 zero and bits 20:0 equal to the command word. `ser_fs` is high during the first bit period only.
- R2: A command with the write flag set delivers its address and data to the codec. When the reply slot ends, status bit 12 (write complete) sets, and the command register reads back the word that was written.
- R3: A command with the write flag clear captures the 16-bit reply, MSB first, into command register bits 15:0. Bits 20:16 keep the address with the flag clear, and status bit 13 (read complete) sets.
- R4: An accepted command clears both completion flags in the cycle after it is written, so at most one flag is ever set.
- R5: A command written while a transaction is pending or in progress is ignored. No extra frame is sent and the command register is unchanged.
- R6: The control register (offset 0x00) holds the enable in bit 16 and the divisor in bits 14:8. Every other bit reads as zero.
- R7: While the enable is clear, `ser_clk` stays low and no frame starts. A command issued in that state stays pending with both flags clear, and it completes once the enable is set.
- R8: With the port enabled and a nonzero divisor D, `rate_stb` pulses for one cycle every 32·D clocks. With D = 0, or with the port disabled, it never pulses.
- R9: After reset, all registers read zero and `ser_clk`, `ser_fs`, `ser_do` and `rate_stb` are low.
- R10: Each bit period lasts BIT_DIV clocks. `ser_do` changes when `ser_clk` falls, and `ser_di` is sampled when `ser_clk` rises. A transaction takes 48 bit periods: 32 outbound bits, then a 16-bit reply slot during which `ser_do` is low.
- R11: Writes to the status register (0x18) or to unmapped offsets change no register. The command register sits at offset 0x10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| ser_clk | output | 1 | Serial bit clock |
| ser_fs | output | 1 | Frame sync, high for the first bit of a frame |
| ser_do | output | 1 | Serial data to the codec |
| ser_di | input | 1 | Serial reply from the codec |
| rate_stb | output | 1 | Telecom sample-rate strobe |

## Verification
The assertions assume that bus accesses last one cycle and that the bus address is always driven. They also assume BIT_DIV is at least 2, so a launch point and a sample point never fall in the same clock. The bench's codec model changes `ser_di` only on the falling edge of `ser_clk`, which keeps reply bits stable at the host's sample point. The randomized part draws addresses, flags and data from a fixed seed. It issues each new command only after the previous one has completed, so an ignored-while-busy command occurs only in the one directed case built for it.

// File: rtl/scrp_pkg.sv
// Package: shared offsets, field positions and the frame engine state type
// for the serial codec register port.
package scrp_pkg;
    // Register byte offsets
    localparam logic [7:0] OFF_CTL  = 8'h00;
    localparam logic [7:0] OFF_CMD  = 8'h10;
    localparam logic [7:0] OFF_STAT = 8'h18;

    // Command word layout
    localparam int REG_ADDR_W   = 4;
    localparam int DATA_W       = 16;
    localparam int CMD_WR_BIT   = DATA_W;
    localparam int CMD_ADDR_LSB = DATA_W + 1;
    localparam int CMD_W        = REG_ADDR_W + 1 + DATA_W;

    // Control layout
    localparam int DIV_W       = 7;
    localparam int CTL_DIV_LSB = 8;
    localparam int CTL_EN_BIT  = 16;

    // Status layout
    localparam int ST_WDONE_BIT = 12;
    localparam int ST_RDONE_BIT = 13;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_ARMED,
        ENG_SHIFT
    } eng_state_e;
endpackage

// File: rtl/scrp_bitclk.sv
// Bit clock divider. While enabled, it divides clk by BIT_DIV and gives a
// launch pulse (end of bit period, ser_clk falls) and a sample pulse
// (mid-period, ser_clk rises). Assumes BIT_DIV >= 2 and even.
// When disabled, it holds ser_clk low.
module scrp_bitclk #(
    parameter int BIT_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic launch,
    output logic sample,
    output logic ser_clk
);
    localparam int CW = (BIT_DIV > 2) ? $clog2(BIT_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(BIT_DIV - 1);
    localparam logic [CW-1:0] MID  = CW'(BIT_DIV / 2 - 1);

    logic [CW-1:0] cnt_q;

    assign launch = en && (cnt_q == LAST);
    assign sample = en && (cnt_q == MID);

    // Phase counter across one bit period
    always_ff @(posedge clk) begin
        if (!rst_n || !en)   cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end

    // Bit clock: rises at sample point, falls at launch point
    always_ff @(posedge clk) begin
        if (!rst_n || !en) ser_clk <= 1'b0;
        else if (launch)   ser_clk <= 1'b0;
        else if (sample)   ser_clk <= 1'b1;
    end
endmodule

// File: rtl/scrp_frame.sv
// Frame engine. Takes a request word on start, waits for the next launch
// point, then shifts FRAME_W bits out MSB first with fs on the first bit,
// then collects REPLY_W reply bits at the sample points. Raises done for
// one cycle at the launch point that ends the reply slot. Assumes start is
// only given while busy is low.
module scrp_frame
    import scrp_pkg::*;
#(
    parameter int FRAME_W = 32,
    parameter int REPLY_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic               sample,
    input  logic               start,
    input  logic [FRAME_W-1:0] start_word,
    input  logic               ser_di,
    output logic               busy,
    output logic               done,
    output logic               ser_fs,
    output logic               ser_do,
    output logic [REPLY_W-1:0] reply
);
    localparam int TOTAL = FRAME_W + REPLY_W;
    localparam int IDX_W = $clog2(TOTAL);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(TOTAL - 1);
    localparam logic [IDX_W-1:0] IDX_OUTLB = IDX_W'(FRAME_W - 1);
    localparam logic [IDX_W-1:0] IDX_RX0   = IDX_W'(FRAME_W);

    eng_state_e        st_q;
    logic [IDX_W-1:0]  idx_q;
    logic [FRAME_W-1:0] sh_q;

    assign busy = (st_q != ENG_IDLE);
    assign done = launch && (st_q == ENG_SHIFT) && (idx_q == IDX_LAST);

    // Sequencer: arm, shift out, run the reply slot, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ENG_IDLE;
            idx_q  <= '0;
            sh_q   <= '0;
            ser_fs <= 1'b0;
            ser_do <= 1'b0;
        end else begin
            case (st_q)
                ENG_IDLE: begin
                    if (start) begin
                        sh_q <= start_word;
                        st_q <= ENG_ARMED;
                    end
                end
                ENG_ARMED: begin
                    if (launch) begin
                        st_q   <= ENG_SHIFT;
                        idx_q  <= '0;
                        ser_fs <= 1'b1;
                        ser_do <= sh_q[FRAME_W-1];
                        sh_q   <= sh_q << 1;
                    end
                end
                ENG_SHIFT: begin
                    if (done) begin
                        st_q   <= ENG_IDLE;
                        ser_fs <= 1'b0;
                        ser_do <= 1'b0;
                    end else if (launch) begin
                        idx_q  <= idx_q + 1'b1;
                        ser_fs <= 1'b0;
                        ser_do <= (idx_q < IDX_OUTLB) ? sh_q[FRAME_W-1] : 1'b0;
                        sh_q   <= sh_q << 1;
                    end
                end
                default: st_q <= ENG_IDLE;
            endcase
        end
    end

    // Reply capture at sample points inside the reply slot
    always_ff @(posedge clk) begin
        if (!rst_n) reply <= '0;
        else if (st_q == ENG_SHIFT && sample && idx_q >= IDX_RX0)
            reply <= {reply[REPLY_W-2:0], ser_di};
    end
endmodule

// File: rtl/scrp_rate.sv
// Telecom rate strobe. Pulses once every 32*div clocks while enabled and
// div is nonzero. clr restarts the period (used on control writes).
module scrp_rate #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             stb
);
    localparam int CNT_W = DIV_W + 5;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_m1;
    logic             run;

    assign run    = en && (div != '0);
    assign lim_m1 = {div, 5'b0} - 1'b1;
    assign stb    = run && (cnt_q == lim_m1);

    // Period counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run) cnt_q <= '0;
        else if (stb)              cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/scrp_port.sv
// Serial codec register access port (top). Holds the control, command and
// status registers on a simple one-cycle register bus and drives the
// bit clock, frame engine and rate strobe. Assumes single-cycle bus
// accesses; reads are combinational and have no side effects.
module scrp_port
    import scrp_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int BIT_DIV = 4,
    parameter int FRAME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              ser_clk,
    output logic              ser_fs,
    output logic              ser_do,
    input  logic              ser_di,
    output logic              rate_stb
);
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFF_CTL);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

    logic              en_q;
    logic [DIV_W-1:0]  div_q;
    logic [CMD_W-1:0]  cmd_q;
    logic              wr_done_q, rd_done_q;

    logic ctl_wr, cmd_acc;
    logic launch, sample;
    logic eng_busy, eng_done;
    logic [DATA_W-1:0] eng_reply;

    wire unused_hi = &{1'b0, bus_wdata[31:CMD_W]};

    assign ctl_wr  = bus_sel && bus_wr && (bus_addr == A_CTL);
    assign cmd_acc = bus_sel && bus_wr && (bus_addr == A_CMD) && !eng_busy;

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            div_q <= '0;
        end else if (ctl_wr) begin
            en_q  <= bus_wdata[CTL_EN_BIT];
            div_q <= bus_wdata[CTL_DIV_LSB +: DIV_W];
        end
    end

    // Command register: loaded on accept, low half replaced by read reply
    always_ff @(posedge clk) begin
        if (!rst_n)                           cmd_q <= '0;
        else if (cmd_acc)                     cmd_q <= bus_wdata[CMD_W-1:0];
        else if (eng_done && !cmd_q[CMD_WR_BIT]) cmd_q[DATA_W-1:0] <= eng_reply;
    end

    // Sticky completion flags
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_acc) begin
            wr_done_q <= 1'b0;
            rd_done_q <= 1'b0;
        end else if (eng_done) begin
            if (cmd_q[CMD_WR_BIT]) wr_done_q <= 1'b1;
            else                   rd_done_q <= 1'b1;
        end
    end

    // Register read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTL) begin
            bus_rdata[CTL_EN_BIT]               = en_q;
            bus_rdata[CTL_DIV_LSB +: DIV_W]     = div_q;
        end else if (bus_addr == A_CMD) begin
            bus_rdata[CMD_W-1:0]                = cmd_q;
        end else if (bus_addr == A_STAT) begin
            bus_rdata[ST_WDONE_BIT]             = wr_done_q;
            bus_rdata[ST_RDONE_BIT]             = rd_done_q;
        end
    end

    scrp_bitclk #(.BIT_DIV(BIT_DIV)) u_bitclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q),
        .launch  (launch),
        .sample  (sample),
        .ser_clk (ser_clk)
    );

    scrp_frame #(.FRAME_W(FRAME_W), .REPLY_W(DATA_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .sample     (sample),
        .start      (cmd_acc),
        .start_word (FRAME_W'(bus_wdata[CMD_W-1:0])),
        .ser_di     (ser_di),
        .busy       (eng_busy),
        .done       (eng_done),
        .ser_fs     (ser_fs),
        .ser_do     (ser_do),
        .reply      (eng_reply)
    );

    scrp_rate #(.DIV_W(DIV_W)) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_q),
        .clr   (ctl_wr),
        .div   (div_q),
        .stb   (rate_stb)
    );
endmodule

// File: rtl/scrp_port_chk.sv
// Checker for scrp_port: temporal properties over the bus, flags, engine
// handshake and serial outputs. Attached by the bind below.
module scrp_port_chk
    import scrp_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              ctl_en,
    input logic              busy,
    input logic              done,
    input logic [1:0]        flags,
    input logic [CMD_W-1:0]  cmd_q,
    input logic              ser_clk,
    input logic              ser_fs,
    input logic              rate_stb
);
    localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(OFF_CMD);

    logic cmd_wr;
    assign cmd_wr = bus_sel && bus_wr && (bus_addr == A_CMD);

    // R4: accepted command leaves both flags clear next cycle
    a_r4_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy) |=> (flags == 2'b00));

    // R4: never both flags
    a_r4_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flags));

    // R5: command while busy does not disturb the command register
    a_r5_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy && !done) |=> $stable(cmd_q));

    // R7: disabled port keeps the bit clock low
    a_r7_clk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> !ser_clk);

    // R10: frame sync only inside a transaction
    a_r10_fs_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        ser_fs |-> busy);

    // R2, R3: a flag rises only as the engine goes idle
    a_r2_flag_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|flags) |-> (!busy && $past(busy)));

    // R8: strobe is a single-cycle pulse
    a_r8_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        rate_stb |=> !rate_stb);
endmodule

bind scrp_port scrp_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .ctl_en   (en_q),
    .busy     (eng_busy),
    .done     (eng_done),
    .flags    ({rd_done_q, wr_done_q}),
    .cmd_q    (cmd_q),
    .ser_clk  (ser_clk),
    .ser_fs   (ser_fs),
    .rate_stb (rate_stb)
);

// File: tb/test_scrp_port.sv
// Bench for scrp_port with a behavioural codec model on the serial link.
module test_scrp_port;
    localparam int BIT_DIV = 4;
    localparam logic [4:0] A_CTL = 5'h00, A_CMD = 5'h10, A_STAT = 5'h18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    wire  [31:0] bus_rdata;
    wire         ser_clk, ser_fs, ser_do, rate_stb;
    logic        ser_di = 1'b0;

    scrp_port #(.ADDR_W(5), .BIT_DIV(BIT_DIV), .FRAME_W(32)) i_scrp_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_clk(ser_clk), .ser_fs(ser_fs), .ser_do(ser_do),
        .ser_di(ser_di), .rate_stb(rate_stb)
    );

    int n_chk = 0, n_bad = 0;

    // ---------------- codec model ----------------
    logic [15:0] cm_regs [16];
    logic [15:0] exp_regs [16];
    logic [31:0] cm_sh = '0, last_frame = '0;
    logic [15:0] cm_rep = '0;
    bit          cm_act = 1'b0;
    int          cm_cnt = 0, frames = 0, clk_rises = 0, do_err = 0, bits_last = 0;

    always @(posedge ser_clk) begin
        clk_rises++;
        if (ser_fs) begin
            cm_act = 1'b1; cm_cnt = 1; cm_sh = {31'b0, ser_do}; frames++;
        end else if (cm_act) begin
            if (cm_cnt < 32) cm_sh = {cm_sh[30:0], ser_do};
            else if (ser_do) do_err++;
            cm_cnt++;
            if (cm_cnt == 32) begin
                last_frame = cm_sh;
                if (cm_sh[16]) begin cm_regs[cm_sh[20:17]] = cm_sh[15:0]; cm_rep = 16'h0; end
                else cm_rep = cm_regs[cm_sh[20:17]];
            end
            if (cm_cnt == 48) begin cm_act = 1'b0; bits_last = cm_cnt; end
        end
    end

    always @(negedge ser_clk)
        if (cm_act && cm_cnt >= 32 && cm_cnt < 48) ser_di = cm_rep[47 - cm_cnt];

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [31:0] cword(input logic [3:0] a, input logic wr, input logic [15:0] d);
        return {11'b0, a, wr, d};
    endfunction

    task automatic wait_done(output logic [31:0] st);
        st = '0;
        for (int i = 0; i < 1000; i++) begin
            bus_read(A_STAT, st);
            if (st[13:12] != 2'b00) break;
        end
    endtask

    // full transaction with checks on R1..R4
    task automatic run_cmd(input logic [3:0] a, input logic wr, input logic [15:0] d);
        logic [31:0] st, rb;
        logic [15:0] expd;
        expd = wr ? d : exp_regs[a];
        bus_write(A_CMD, cword(a, wr, d));
        bus_read(A_STAT, st);
        chk("R4 flags cleared on new command", st, 32'h0);
        wait_done(st);
        chk(wr ? "R2 write-complete status" : "R3 read-complete status",
            st, wr ? 32'h1000 : 32'h2000);
        chk("R1 outbound frame", last_frame, cword(a, wr, d));
        bus_read(A_CMD, rb);
        chk(wr ? "R2 command readback" : "R3 read data in command reg",
            rb, cword(a, wr, expd));
        if (wr) begin
            exp_regs[a] = d;
            chk("R2 codec register written", {16'h0, cm_regs[a]}, {16'h0, d});
        end
    endtask

    task automatic measure_stb(output int period);
        int n;
        period = -1;
        n = 0;
        while (!rate_stb && n < 5000) begin @(negedge clk); n++; end
        @(negedge clk);
        n = 1;
        while (!rate_stb && n < 5000) begin @(negedge clk); n++; end
        period = n;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        logic [31:0] v, st0, ct0, cm0;
        int r0, f0, per, cnt;
        for (int i = 0; i < 16; i++) begin cm_regs[i] = '0; exp_regs[i] = '0; end
        void'($urandom(32'h00C0DEC5));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        bus_read(A_CTL, v);  chk("R9 control after reset", v, 0);
        bus_read(A_CMD, v);  chk("R9 command after reset", v, 0);
        bus_read(A_STAT, v); chk("R9 status after reset", v, 0);
        chk("R9 serial outputs low", {29'b0, ser_clk, ser_fs, ser_do}, 0);
        chk("R9 strobe low", {31'b0, rate_stb}, 0);

        // R6 control fields
        bus_write(A_CTL, 32'hFFFF_FFFF);
        bus_read(A_CTL, v); chk("R6 control masks reserved bits", v, 32'h0001_7F00);
        bus_write(A_CTL, 32'h0001_0300);
        bus_read(A_CTL, v); chk("R6 control readback", v, 32'h0001_0300);

        // R8 strobe period with divisor 3
        measure_stb(per); chk("R8 strobe period div=3", per, 96);

        // R10 bit period
        begin
            time t0, t1;
            @(posedge ser_clk); t0 = $time;
            @(posedge ser_clk); t1 = $time;
            chk("R10 bit period in clocks", (t1 - t0) / 10, BIT_DIV);
        end

        // directed write and read (R1 R2 R3 R10)
        do_err = 0;
        run_cmd(4'h9, 1'b1, 16'hA55A);
        chk("R10 reply-slot bit count", bits_last, 48);
        run_cmd(4'h9, 1'b0, 16'h0000);
        run_cmd(4'hF, 1'b1, 16'hFFFF);
        run_cmd(4'h0, 1'b1, 16'h8001);
        run_cmd(4'hF, 1'b0, 16'h1234);
        chk("R10 ser_do low during reply slot", do_err, 0);

        // R5 command while busy is ignored
        f0 = frames;
        bus_write(A_CMD, cword(4'h5, 1'b1, 16'h1234));
        bus_write(A_CMD, cword(4'h6, 1'b1, 16'hBEEF));
        wait_done(v);
        exp_regs[5] = 16'h1234;
        chk("R5 only one frame sent", frames - f0, 1);
        chk("R5 codec got first command", last_frame, cword(4'h5, 1'b1, 16'h1234));
        bus_read(A_CMD, v); chk("R5 command register kept", v, cword(4'h5, 1'b1, 16'h1234));
        chk("R5 second address untouched", {16'h0, cm_regs[6]}, {16'h0, exp_regs[6]});

        // R11 writes to status / unmapped offsets
        bus_read(A_STAT, st0); bus_read(A_CTL, ct0); bus_read(A_CMD, cm0);
        bus_write(A_STAT, 32'hFFFF_FFFF);
        bus_write(5'h04, 32'hFFFF_FFFF);
        bus_write(5'h1C, 32'h0000_0000);
        bus_read(A_STAT, v); chk("R11 status unchanged", v, st0);
        bus_read(A_CTL, v);  chk("R11 control unchanged", v, ct0);
        bus_read(A_CMD, v);  chk("R11 command unchanged", v, cm0);

        // R7 disabled port: no frames, command pending, then completes
        bus_write(A_CTL, 32'h0000_0300);
        r0 = clk_rises; f0 = frames;
        bus_write(A_CMD, cword(4'h3, 1'b1, 16'h0F0F));
        repeat (300) @(negedge clk);
        chk("R7 bit clock quiet while disabled", clk_rises - r0, 0);
        chk("R7 no frame while disabled", frames - f0, 0);
        bus_read(A_STAT, v); chk("R7 no completion while disabled", v, 0);
        bus_write(A_CTL, 32'h0001_0300);
        wait_done(v);
        exp_regs[3] = 16'h0F0F;
        chk("R7 completes after enable", v, 32'h1000);
        chk("R7 codec register written", {16'h0, cm_regs[3]}, 32'h0F0F);

        // R8 no strobe with div 0 or disabled; other divisor
        bus_write(A_CTL, 32'h0001_0000);
        cnt = 0; repeat (400) begin @(negedge clk); if (rate_stb) cnt++; end
        chk("R8 no strobe with divisor 0", cnt, 0);
        bus_write(A_CTL, 32'h0000_0500);
        cnt = 0; repeat (400) begin @(negedge clk); if (rate_stb) cnt++; end
        chk("R8 no strobe while disabled", cnt, 0);
        bus_write(A_CTL, 32'h0001_0100);
        measure_stb(per); chk("R8 strobe period div=1", per, 32);
        bus_write(A_CTL, 32'h0001_0700);

        // random transactions (R1 R2 R3 R4)
        for (int k = 0; k < 40; k++) begin
            logic [3:0] ra;
            logic rw;
            logic [15:0] rd;
            ra = 4'($urandom);
            rw = 1'($urandom);
            rd = 16'($urandom);
            run_cmd(ra, rw, rd);
        end
        chk("R10 ser_do low during reply slot (random)", do_err, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule